// File: doc/BRIEF.md
# Two-Stage System Watchdog

This block is a system-management watchdog. It counts down in coarse ticks, where a free-running prescaler makes one tick every `PRESCALE` system clocks. With the default settings a tick is about 0.6 s at 50 MHz. Software reaches the block through a small synchronous register port. It programs a 10-bit period, releases a halt bit, and then services the timer by writing to a reload register. The value written to the reload register does not matter.

When the timer is not serviced, expiry happens in two stages. The first expiry latches a first-timeout status bit. If the interrupt enable is set, this raises a management interrupt. The counter then reloads on its own and starts a second countdown. If that second countdown also runs out, the block latches a second-timeout status bit and emits a one-cycle system-reset pulse, together with a boot status bit. A no-reboot control bit blocks the pulse. A reload during the second countdown cancels the pending reset.

Top module: `sys_watchdog`

## Requirements
- R1: After reset the registers read as follows: control reads 0x0001 (halt set), period reads 0x03FF and status reads 0. `sys_rst_o` and `irq_o` are low.
- R2: The prescaler makes one tick every `PRESCALE` clocks and never stops. On a tick, while not halted, the count drops by one. A tick that finds the count at 0 is an expiry and reloads the count. An expiry therefore comes `eff+1` ticks after a load, where `eff` is the effective period.
- R3: While control bit 0 (halt) is 1, the count does not change except through a reload write.
- R4: Any write to address 2 loads the count with the effective period in the next cycle, whatever data is written. The timer returns to the first stage. Address 2 reads 0.
- R5: The period is bits [9:0] of address 1. Bits [15:10] read 0, and writing them has no effect. A period of 0 counts as `MIN_TICKS`.
- R6: The first expiry sets status bit 0, reloads the count and enters the second stage.
- R7: `irq_o` is high exactly while status bit 0 and control bit 1 (interrupt enable) are both 1.
- R8: A second expiry sets status bit 1 and reloads into the first stage. If control bit 2 (no-reboot) is 0, it also sets status bit 2 (boot) and drives `sys_rst_o` high for exactly one cycle.
- R9: While no-reboot is 1, a second expiry produces no reset pulse and leaves boot status unchanged.
- R10: Writing a 1 to a status bit position at address 3 clears that bit, and writing 0 leaves it. A hardware set in the same cycle wins over the clear.
- R11: A reload write during the second stage cancels the pending reset.
- R12: Address 4 reads the current count, zero-extended. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Management interrupt, level |
| sys_rst_o | output | 1 | System-reset request, one-cycle pulse |

## Verification
The bench targets the following corner cases:
- The off-by-one in the expiry point: a design that expires when the count reaches 0, rather than on the tick after, fires one tick early.
- The same-cycle collisions, reload against expiry and clear against set: a design that gets the priority wrong loses a status bit or skips a reload.
- Stage handling: a design that does not return to the first stage on reload would reset a serviced system. A design that ignores no-reboot would reset a system that asked not to be reset.
- Period edge cases: a zero period must count as the minimum, and the upper period bits must not be writable.

// File: rtl/sys_watchdog.sv
module sys_watchdog #(
  parameter int PRESCALE  = 30000000,
  parameter int MIN_TICKS = 4,
  parameter int PERIOD_W  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_PER = 3'd1, A_RLD = 3'd2, A_STS = 3'd3, A_CNT = 3'd4;
  localparam logic [PERIOD_W-1:0] PER_MAX = '1;

  logic [PRE_W-1:0]    pre_q;
  logic [PERIOD_W-1:0] cnt_q, period_q, eff;
  logic halt_q, irqen_q, nr_q, stage_q, s1_q, s2_q, boot_q, rst_q;
  logic tick, wr, wr_ctrl, wr_per, wr_rld, wr_sts;

  assign tick    = (pre_q == PRE_W'(PRESCALE - 1));
  assign wr      = bus_sel & bus_we;
  assign wr_ctrl = wr & (bus_addr == A_CTRL);
  assign wr_per  = wr & (bus_addr == A_PER);
  assign wr_rld  = wr & (bus_addr == A_RLD);
  assign wr_sts  = wr & (bus_addr == A_STS);
  assign eff     = (period_q == '0) ? PERIOD_W'(MIN_TICKS) : period_q;
  assign irq_o     = s1_q & irqen_q;
  assign sys_rst_o = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0; cnt_q <= PER_MAX; period_q <= PER_MAX;
      halt_q <= 1'b1; irqen_q <= 1'b0; nr_q <= 1'b0; stage_q <= 1'b0;
      s1_q <= 1'b0; s2_q <= 1'b0; boot_q <= 1'b0; rst_q <= 1'b0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      rst_q <= 1'b0;
      if (wr_ctrl) begin
        halt_q  <= bus_wdata[0];
        irqen_q <= bus_wdata[1];
        nr_q    <= bus_wdata[2];
      end
      if (wr_per) period_q <= bus_wdata[PERIOD_W-1:0];
      if (wr_sts) begin
        if (bus_wdata[0]) s1_q   <= 1'b0;
        if (bus_wdata[1]) s2_q   <= 1'b0;
        if (bus_wdata[2]) boot_q <= 1'b0;
      end
      if (wr_rld) begin
        cnt_q   <= eff;
        stage_q <= 1'b0;
      end else if (tick && !halt_q) begin
        if (cnt_q == '0) begin
          cnt_q <= eff;
          if (!stage_q) begin
            s1_q    <= 1'b1;
            stage_q <= 1'b1;
          end else begin
            s2_q    <= 1'b1;
            stage_q <= 1'b0;
            if (!nr_q) begin
              rst_q  <= 1'b1;
              boot_q <= 1'b1;
            end
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {13'd0, nr_q, irqen_q, halt_q};
      A_PER:   bus_rdata = 16'(period_q);
      A_STS:   bus_rdata = {13'd0, boot_q, s2_q, s1_q};
      A_CNT:   bus_rdata = 16'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end

  a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_rld) |=> $stable(cnt_q));
  a_r4_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rld |=> (cnt_q == $past(eff) && !stage_q));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);
  a_r8_pulse_status: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (s2_q && boot_q));
  a_r9_no_reboot: assert property (@(posedge clk) disable iff (!rst_n)
    nr_q |=> !sys_rst_o);
  a_r6_stage_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_q) |-> s1_q);
endmodule

// File: tb/tb_sys_watchdog.sv
module tb_sys_watchdog;
  localparam int PRE = 4, MINT = 4;
  logic clk = 0, rst_n = 0, sel = 0, we = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq, srst;
  int tests = 0, fails = 0, pulses = 0;
  bit done = 0;

  sys_watchdog #(.PRESCALE(PRE), .MIN_TICKS(MINT), .PERIOD_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .sys_rst_o(srst));

  always #10 clk = ~clk;

  int m_pre, m_cnt, m_per, m_stage, m_halt, m_ien, m_nr, m_s1, m_s2, m_boot, m_rst;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 1023; m_per = 1023; m_stage = 0; m_halt = 1; m_ien = 0;
      m_nr = 0; m_s1 = 0; m_s2 = 0; m_boot = 0; m_rst = 0;
    end else begin
      int e; bit tk, oh;
      tk = (m_pre == PRE - 1); oh = m_halt[0];
      e = (m_per == 0) ? MINT : m_per;
      m_pre = tk ? 0 : m_pre + 1;
      m_rst = 0;
      if (sel && we) begin
        case (addr)
          0: begin m_halt = wdata[0]; m_ien = wdata[1]; m_nr = wdata[2]; end
          1: m_per = wdata[9:0];
          3: begin if (wdata[0]) m_s1 = 0; if (wdata[1]) m_s2 = 0; if (wdata[2]) m_boot = 0; end
          default: ;
        endcase
      end
      if (sel && we && addr == 2) begin m_cnt = e; m_stage = 0; end
      else if (tk && !oh) begin
        if (m_cnt == 0) begin
          m_cnt = e;
          if (m_stage == 0) begin m_s1 = 1; m_stage = 1; end
          else begin
            m_s2 = 1; m_stage = 0;
            if (!m_nr) begin m_rst = 1; m_boot = 1; end
          end
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  function automatic int exp_rd(input logic [2:0] a);
    case (a)
      0: return m_nr * 4 + m_ien * 2 + m_halt;
      1: return m_per;
      3: return m_boot * 4 + m_s2 * 2 + m_s1;
      4: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    #3;
    chk("R8 sys_rst_o", int'(srst), m_rst);
    chk("R7 irq_o", int'(irq), m_s1 & m_ien);
    case (addr)
      0: chk("R1 ctrl read", int'(rdata), exp_rd(addr));
      1: chk("R5 period read", int'(rdata), exp_rd(addr));
      3: chk("R10 status read", int'(rdata), exp_rd(addr));
      4: chk("R2 R12 count read", int'(rdata), exp_rd(addr));
      default: chk("R4 other read", int'(rdata), exp_rd(addr));
    endcase
  end

  always @(negedge clk) if (srst) pulses++;

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); addr = a; #4; v = int'(rdata);
  endtask

  task automatic wait_sts(input int mask, input int lim);
    int v;
    for (int i = 0; i < lim; i++) begin
      rd(3, v);
      if ((v & mask) != 0) break;
    end
  endtask

  initial begin
    int v, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 ctrl reset", v, 1);
    rd(1, v); chk("R1 period reset", v, 16'h03FF);
    rd(3, v); chk("R1 status reset", v, 0);
    chk("R1 outputs low", int'(srst) + int'(irq), 0);

    wr(1, 16'hFC05);
    rd(1, v); chk("R5 upper bits ignored", v, 5);
    wr(2, 16'hBEEF);
    rd(4, v); chk("R4 reload any data", v, 5);
    rd(2, v); chk("R4 reload reads zero", v, 0);
    wr(4, 16'h0077);
    rd(4, v); chk("R12 count not writable", v, 5);
    repeat (40) @(negedge clk);
    rd(4, v); chk("R3 halted count frozen", v, 5);

    wr(0, 16'h0002);
    wait_sts(1, 200);
    rd(3, v); chk("R6 first expiry status", v, 1);
    chk("R7 irq raised", int'(irq), 1);
    wait_sts(2, 200);
    rd(3, v); chk("R8 second expiry status", v, 7);
    chk("R8 one reset pulse", pulses, 1);

    wr(3, 16'h0002);
    rd(3, v); chk("R10 clear only bit1", v, 5);
    wr(3, 16'h0005);
    rd(3, v); chk("R10 status cleared", v, 0);
    chk("R7 irq dropped", int'(irq), 0);

    wr(0, 16'h0004); wr(2, 0);
    wait_sts(2, 300);
    rd(3, v); chk("R9 no boot status", v, 3);
    chk("R9 no pulse", pulses, 1);

    wr(3, 16'h0007); wr(0, 16'h0000); wr(2, 0);
    wait_sts(1, 200);
    p0 = pulses;
    for (int i = 0; i < 15; i++) begin wr(2, 16'h1234); repeat (8) @(negedge clk); end
    rd(3, v); chk("R11 reset cancelled", v & 2, 0);
    chk("R11 no pulse", pulses, p0);

    wr(0, 16'h0001); wr(1, 0); wr(2, 0);
    rd(4, v); chk("R5 zero period is minimum", v, MINT);
    repeat (5) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog expired (R2)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule